// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block counts hardware events that arrive every cycle from three kinds of source: a set of cache-lookup lanes, a set of tracker-allocation lanes and an occupancy level that reports how many tracker entries are currently valid. An 8-bit event code picks the source and an 8-bit unit mask picks which events of that source count. Every cycle the block forms the number of selected events, then a qualifier stage decides what to add. It can add the raw count, add one when the count reaches a threshold, add one when the count stays below the threshold (inverted), or add one only on the cycle where the qualified condition first becomes true (edge mode).

Software programs one configuration word and reads or writes a 48-bit counter through a small register port with a single address bit. Several copies of the block are expected side by side, and each is told its index through a parameter. Only index 0 may accumulate occupancy. Any other copy that is programmed for occupancy keeps its value.

Top module: `evt_counter_top`

## Requirements
- R1: Event code 0x34 counts cache-lookup lanes. A lane with valid set counts when the unit-mask bit selected by its 2-bit state (0=M→bit0, 1=E→bit1, 2=S→bit2, 3=I→bit3) is set, and its 2-bit kind also matches a filter. Kinds 0 (read), 1 (write) and 2 (external snoop) match bits 4, 5 and 6. Unit-mask bit 7 (any) matches every kind, including kind 3 (other).
- R2: Event code 0x81 counts allocation lanes with valid set. Unit-mask bit 0 matches every lane, bit 5 matches lanes flagged write, and bit 7 matches lanes flagged eviction. Any other code except 0x80 selects zero events.
- R3: With threshold 0 and edge mode off, the counter adds the raw per-cycle count of selected events, and the invert flag has no effect.
- R4: With a nonzero threshold, the counter adds one in a cycle where the selected count is greater than or equal to the threshold, and adds nothing otherwise.
- R5: With a nonzero threshold and invert set, the counter adds one in a cycle where the selected count is below the threshold.
- R6: In edge mode the condition is (count ≥ threshold), or its inverse when invert is set, or (count ≠ 0) when the threshold is 0. The counter adds one only in a cycle where the condition is true and was false in the previous cycle. A configuration write makes the previous-cycle value read as false.
- R7: Event code 0x80 adds the occupancy level every cycle on a block with index 0. On any other index it leaves the counter unchanged, whatever the qualifiers are.
- R8: While the enable bit is clear, the counter holds its value.
- R9: Address 1 reads and writes the 48-bit counter. A write to the counter wins over an increment in the same cycle. The counter wraps modulo 2^48. Each change is visible on the read data one cycle after the edge that made it.
- R10: Address 0 reads back the configuration word: code in [7:0], unit mask in [15:8], threshold in [23:16], edge in bit 24, invert in bit 25, enable in bit 26, and zeros above. After reset the configuration and the counter read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | NLOOK | Cache-lookup lane valid |
| lk_state | input | 2*NLOOK | Line state per lookup lane |
| lk_kind | input | 2*NLOOK | Request kind per lookup lane |
| rq_valid | input | NREQ | Allocation lane valid |
| rq_write | input | NREQ | Allocation lane is a write |
| rq_evict | input | NREQ | Allocation lane is an eviction |
| occ_level | input | OCC_W | Number of valid tracker entries this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = counter |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Register read data for reg_addr |

## Verification
A wrong per-cycle count or a wrong qualifier decision changes the counter value on the very next edge, so comparing the read value on every cycle pins a fault to the cycle that caused it. A stale or uncleared edge register is harder to see. It shows only as a missing or extra single increment on the first cycle of a true condition, so the bench holds conditions true across many cycles and rewrites the configuration while a condition is true. An occupancy block on the wrong index shows up at once as a counter that moves on the copy with index 1.

// File: rtl/evc_pkg.sv
// Package: shared constants and the configuration record for the event counter.
// Assumes per-cycle event counts and thresholds fit in EVW bits.
package evc_pkg;

    localparam int EVW = 8;                    // per-cycle count and threshold width
    localparam logic [7:0] EV_LOOKUP = 8'h34;  // cache lookup lanes
    localparam logic [7:0] EV_OCC    = 8'h80;  // tracker occupancy (index 0 only)
    localparam logic [7:0] EV_ALLOC  = 8'h81;  // tracker allocations

    // Bit positions inside the configuration word.
    localparam int CF_EDGE = 24;
    localparam int CF_INV  = 25;
    localparam int CF_EN   = 26;
    localparam int CF_BITS = 27;

    typedef struct packed {
        logic           en;
        logic           inv;
        logic           edge_on;
        logic [EVW-1:0] thresh;
        logic [7:0]     umask;
        logic [7:0]     code;
    } evc_cfg_t;

endpackage

// File: rtl/evt_select.sv
// Module: evt_select
// Turns the raw source lanes into the number of selected events for this cycle.
// Assumes NLOOK and NREQ are below 2**EVW and OCC_W <= EVW. Purely combinational.
module evt_select
    import evc_pkg::*;
#(
    parameter int NLOOK = 4,
    parameter int NREQ  = 4,
    parameter int OCC_W = 6
) (
    input  logic [7:0]         code,
    input  logic [7:0]         umask,
    input  logic [NLOOK-1:0]   lk_valid,
    input  logic [2*NLOOK-1:0] lk_state,
    input  logic [2*NLOOK-1:0] lk_kind,
    input  logic [NREQ-1:0]    rq_valid,
    input  logic [NREQ-1:0]    rq_write,
    input  logic [NREQ-1:0]    rq_evict,
    input  logic [OCC_W-1:0]   occ_level,
    output logic [EVW-1:0]     ev_count
);

    logic [NLOOK-1:0] lk_hit;
    logic [NREQ-1:0]  rq_hit;
    logic [EVW-1:0]   lk_sum;
    logic [EVW-1:0]   rq_sum;

    // Per-lane match of lookup state and request filter groups.
    genvar gl;
    generate
        for (gl = 0; gl < NLOOK; gl++) begin : g_lk
            logic [1:0] st;
            logic [1:0] kd;
            logic       st_ok;
            logic       kd_ok;
            assign st = lk_state[2*gl +: 2];
            assign kd = lk_kind[2*gl +: 2];
            assign st_ok = umask[st];
            assign kd_ok = umask[7] || ((kd != 2'd3) && umask[3'd4 + {1'b0, kd}]);
            assign lk_hit[gl] = lk_valid[gl] && st_ok && kd_ok;
        end
        for (gl = 0; gl < NREQ; gl++) begin : g_rq
            assign rq_hit[gl] = rq_valid[gl] &&
                                (umask[0] || (umask[5] && rq_write[gl]) ||
                                 (umask[7] && rq_evict[gl]));
        end
    endgenerate

    // Population count of lookup lane hits.
    always_comb begin
        lk_sum = '0;
        for (int i = 0; i < NLOOK; i++) begin
            lk_sum = lk_sum + EVW'(lk_hit[i]);
        end
    end

    // Population count of allocation lane hits.
    always_comb begin
        rq_sum = '0;
        for (int i = 0; i < NREQ; i++) begin
            rq_sum = rq_sum + EVW'(rq_hit[i]);
        end
    end

    // Source select by event code.
    always_comb begin
        unique case (code)
            EV_LOOKUP: ev_count = lk_sum;
            EV_ALLOC:  ev_count = rq_sum;
            EV_OCC:    ev_count = EVW'(occ_level);
            default:   ev_count = '0;
        endcase
    end

endmodule

// File: rtl/evt_qualify.sv
// Module: evt_qualify
// Converts the per-cycle event count into the amount to add, applying the
// threshold, invert and edge qualifiers. Holds the one-cycle copy of the
// qualified condition used by edge mode; clr empties that copy.
module evt_qualify
    import evc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           blocked,
    input  logic           edge_on,
    input  logic           inv,
    input  logic [EVW-1:0] thresh,
    input  logic [EVW-1:0] ev_count,
    output logic [EVW-1:0] step
);

    logic cond;
    logic cond_q;
    logic thr_on;

    assign thr_on = (thresh != '0);

    // Qualified condition for this cycle.
    always_comb begin
        if (blocked) begin
            cond = 1'b0;
        end else if (!thr_on) begin
            cond = (ev_count != '0);
        end else if (inv) begin
            cond = (ev_count < thresh);
        end else begin
            cond = (ev_count >= thresh);
        end
    end

    // Amount added this cycle.
    always_comb begin
        if (blocked) begin
            step = '0;
        end else if (edge_on) begin
            step = EVW'(cond && !cond_q);
        end else if (!thr_on) begin
            step = ev_count;
        end else begin
            step = EVW'(cond);
        end
    end

    // Previous-cycle condition register for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cond_q <= 1'b0;
        end else begin
            cond_q <= cond;
        end
    end

    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && (step != '0) && !clr) |=> (step == '0)); // R6

    AST_THRESH_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_on && !edge_on) |-> (step <= EVW'(1))); // R4

endmodule

// File: rtl/evt_accum.sv
// Module: evt_accum
// Holds the configuration word and the counter, serves the register port and
// adds the qualified step while enabled. A counter write wins over counting.
module evt_accum
    import evc_pkg::*;
#(
    parameter int CW = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic           reg_addr,
    input  logic [CW-1:0]  reg_wdata,
    input  logic [EVW-1:0] step,
    output evc_cfg_t       cfg,
    output logic           cfg_wr,
    output logic [CW-1:0]  count,
    output logic [CW-1:0]  reg_rdata
);

    localparam int PADW = CW - CF_BITS;

    evc_cfg_t      cfg_q;
    logic [CW-1:0] cnt_q;
    logic          cnt_wr;

    assign cfg_wr = reg_we && !reg_addr;
    assign cnt_wr = reg_we && reg_addr;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.code    <= reg_wdata[7:0];
            cfg_q.umask   <= reg_wdata[15:8];
            cfg_q.thresh  <= reg_wdata[23:16];
            cfg_q.edge_on <= reg_wdata[CF_EDGE];
            cfg_q.inv     <= reg_wdata[CF_INV];
            cfg_q.en      <= reg_wdata[CF_EN];
        end
    end

    // Counter: software write first, then enabled accumulate with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= reg_wdata;
        end else if (cfg_q.en) begin
            cnt_q <= cnt_q + CW'(step);
        end
    end

    // Read mux.
    always_comb begin
        if (reg_addr) begin
            reg_rdata = cnt_q;
        end else begin
            reg_rdata = {{PADW{1'b0}}, cfg_q.en, cfg_q.inv, cfg_q.edge_on,
                         cfg_q.thresh, cfg_q.umask, cfg_q.code};
        end
    end

    assign cfg   = cfg_q;
    assign count = cnt_q;

    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(reg_wdata))); // R9

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !cnt_wr) |=> $stable(cnt_q)); // R8

    AST_CFG_RB: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q.code == $past(reg_wdata[7:0]))); // R10

endmodule

// File: rtl/evt_counter_top.sv
// Module: evt_counter_top
// One programmable event counter: source select, qualifier and accumulator.
// CTR_IDX tells the copy its position; occupancy counts only at index 0.
module evt_counter_top
    import evc_pkg::*;
#(
    parameter int NLOOK   = 4,
    parameter int NREQ    = 4,
    parameter int OCC_W   = 6,
    parameter int CW      = 48,
    parameter int CTR_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLOOK-1:0]   lk_valid,
    input  logic [2*NLOOK-1:0] lk_state,
    input  logic [2*NLOOK-1:0] lk_kind,
    input  logic [NREQ-1:0]    rq_valid,
    input  logic [NREQ-1:0]    rq_write,
    input  logic [NREQ-1:0]    rq_evict,
    input  logic [OCC_W-1:0]   occ_level,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [CW-1:0]      reg_wdata,
    output logic [CW-1:0]      reg_rdata
);

    localparam bit OCC_OK = (CTR_IDX == 0);

    evc_cfg_t       cfg;
    logic           cfg_wr;
    logic [CW-1:0]  count;
    logic [EVW-1:0] ev_count;
    logic [EVW-1:0] step;
    logic           blocked;

    // Occupancy on a non-zero index is refused.
    assign blocked = (cfg.code == EV_OCC) && !OCC_OK;

    evt_select #(.NLOOK(NLOOK), .NREQ(NREQ), .OCC_W(OCC_W)) u_sel (
        .code      (cfg.code),
        .umask     (cfg.umask),
        .lk_valid  (lk_valid),
        .lk_state  (lk_state),
        .lk_kind   (lk_kind),
        .rq_valid  (rq_valid),
        .rq_write  (rq_write),
        .rq_evict  (rq_evict),
        .occ_level (occ_level),
        .ev_count  (ev_count)
    );

    evt_qualify u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_wr),
        .blocked  (blocked),
        .edge_on  (cfg.edge_on),
        .inv      (cfg.inv),
        .thresh   (cfg.thresh),
        .ev_count (ev_count),
        .step     (step)
    );

    evt_accum #(.CW(CW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .step      (step),
        .cfg       (cfg),
        .cfg_wr    (cfg_wr),
        .count     (count),
        .reg_rdata (reg_rdata)
    );

    generate
        if (!OCC_OK) begin : g_occ_chk
            AST_OCC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                ((cfg.code == EV_OCC) && !(reg_we && reg_addr)) |=> $stable(count)); // R7
        end
    endgenerate

    AST_RAW_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !cfg.edge_on && (cfg.thresh == '0) && !blocked && !(reg_we && reg_addr))
        |=> (count == $past(count) + CW'($past(ev_count)))); // R3

endmodule

// File: tb/tb_evt_counter_top.sv
module tb_evt_counter_top;

    localparam int NL = 4;
    localparam int NR = 4;
    localparam int OW = 6;
    localparam int CW = 48;
    localparam logic [CW-1:0] MASK = {CW{1'b1}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   lk_valid = '0;
    logic [2*NL-1:0] lk_state = '0;
    logic [2*NL-1:0] lk_kind = '0;
    logic [NR-1:0]   rq_valid = '0;
    logic [NR-1:0]   rq_write = '0;
    logic [NR-1:0]   rq_evict = '0;
    logic [OW-1:0]   occ_level = '0;
    logic            reg_we = 1'b0;
    logic            reg_addr = 1'b1;
    logic [CW-1:0]   reg_wdata = '0;
    logic [CW-1:0]   rd0, rd1;

    always #10 clk = ~clk;

    evt_counter_top #(.NLOOK(NL), .NREQ(NR), .OCC_W(OW), .CW(CW), .CTR_IDX(0)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_state(lk_state),
        .lk_kind(lk_kind), .rq_valid(rq_valid), .rq_write(rq_write),
        .rq_evict(rq_evict), .occ_level(occ_level), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd0));

    evt_counter_top #(.NLOOK(NL), .NREQ(NR), .OCC_W(OW), .CW(CW), .CTR_IDX(1)) dut1 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_state(lk_state),
        .lk_kind(lk_kind), .rq_valid(rq_valid), .rq_write(rq_write),
        .rq_evict(rq_evict), .occ_level(occ_level), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd1));

    int total = 0;
    int bad = 0;
    string tag = "R10";
    bit done = 0;

    // Reference model state.
    logic [CW-1:0] m_cnt [2];
    logic          m_cq  [2];
    logic [CW-1:0] m_cfg;

    task automatic chk(string r, logic [CW-1:0] act, logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic int sel_count();
        int n = 0;
        logic [7:0] code = m_cfg[7:0];
        logic [7:0] um = m_cfg[15:8];
        if (code == 8'h34) begin
            for (int i = 0; i < NL; i++) begin
                int st = lk_state[2*i +: 2];
                int kd = lk_kind[2*i +: 2];
                bit fok = um[7] || (kd < 3 && um[4 + kd]);
                if (lk_valid[i] && um[st] && fok) n++;
            end
        end else if (code == 8'h81) begin
            for (int i = 0; i < NR; i++) begin
                if (rq_valid[i] && (um[0] || (um[5] && rq_write[i]) || (um[7] && rq_evict[i]))) n++;
            end
        end else if (code == 8'h80) begin
            n = occ_level;
        end
        return n;
    endfunction

    // One clock: predict from current inputs, clock, then compare at the negedge.
    task automatic cycle();
        logic [CW-1:0] nxt [2];
        logic          ncq [2];
        logic [CW-1:0] ncfg = m_cfg;
        int  n = sel_count();
        int  th = m_cfg[23:16];
        bit  edg = m_cfg[24];
        bit  inv = m_cfg[25];
        bit  en = m_cfg[26];
        for (int k = 0; k < 2; k++) begin
            bit blk = (m_cfg[7:0] == 8'h80) && (k != 0);
            bit cnd;
            int stp;
            if (blk) cnd = 0;
            else if (th == 0) cnd = (n != 0);
            else if (inv) cnd = (n < th);
            else cnd = (n >= th);
            if (blk) stp = 0;
            else if (edg) stp = (cnd && !m_cq[k]) ? 1 : 0;
            else if (th == 0) stp = n;
            else stp = cnd ? 1 : 0;
            nxt[k] = m_cnt[k];
            if (reg_we && reg_addr) nxt[k] = reg_wdata;
            else if (en) nxt[k] = (m_cnt[k] + CW'(stp)) & MASK;
            ncq[k] = (reg_we && !reg_addr) ? 1'b0 : cnd;
        end
        if (reg_we && !reg_addr) ncfg = {21'd0, reg_wdata[26:0]};
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            m_cnt[k] = nxt[k];
            m_cq[k] = ncq[k];
        end
        m_cfg = ncfg;
        if (reg_addr) begin
            chk({tag, " cnt0"}, rd0, m_cnt[0]);
            chk({tag, " cnt1"}, rd1, m_cnt[1]);
        end else begin
            chk("R10 cfg0", rd0, m_cfg);
            chk("R10 cfg1", rd1, m_cfg);
        end
    endtask

    task automatic wcfg(logic [7:0] code, logic [7:0] um, logic [7:0] th,
                        bit edg, bit inv, bit en);
        reg_we = 1; reg_addr = 0;
        reg_wdata = {21'd0, en, inv, edg, th, um, code};
        cycle();
        reg_we = 0; reg_addr = 1;
    endtask

    task automatic wcnt(logic [CW-1:0] v);
        reg_we = 1; reg_addr = 1; reg_wdata = v;
        cycle();
        reg_we = 0;
    endtask

    task automatic rnd_in();
        lk_valid = NL'($urandom); lk_state = (2*NL)'($urandom);
        lk_kind = (2*NL)'($urandom);
        rq_valid = NR'($urandom); rq_write = NR'($urandom); rq_evict = NR'($urandom);
        occ_level = OW'($urandom);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            rnd_in();
            cycle();
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_cnt[0] = '0; m_cnt[1] = '0; m_cq[0] = 0; m_cq[1] = 0; m_cfg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state of both registers
        reg_addr = 0; #1;
        chk("R10 reset cfg", rd0, '0);
        reg_addr = 1; #1;
        chk("R10 reset cnt", rd0, '0);
        chk("R10 reset cnt idx1", rd1, '0);

        // R1: lookup matching with several state/filter pairings
        tag = "R1";
        wcfg(8'h34, 8'h11, 8'd0, 0, 0, 1); run(30);
        wcfg(8'h34, 8'h82, 8'd0, 0, 0, 1); run(30);
        wcfg(8'h34, 8'h6C, 8'd0, 0, 0, 1); run(30);
        wcfg(8'h34, 8'h0F, 8'd0, 0, 0, 1); run(20);
        wcfg(8'h34, 8'hF0, 8'd0, 0, 0, 1); run(20);
        wcfg(8'h34, 8'hFF, 8'd0, 0, 0, 1); run(30);

        // R2: allocation lanes and unknown codes
        tag = "R2";
        wcfg(8'h81, 8'h01, 8'd0, 0, 0, 1); run(30);
        wcfg(8'h81, 8'h20, 8'd0, 0, 0, 1); run(30);
        wcfg(8'h81, 8'hA0, 8'd0, 0, 0, 1); run(30);
        wcfg(8'h55, 8'hFF, 8'd0, 0, 0, 1); run(20);

        // R3: raw add, invert ignored when threshold is zero
        tag = "R3";
        wcfg(8'h81, 8'h01, 8'd0, 0, 1, 1); run(40);

        // R4: threshold compare
        tag = "R4";
        wcfg(8'h34, 8'hFF, 8'd2, 0, 0, 1); run(40);
        wcfg(8'h81, 8'h01, 8'd4, 0, 0, 1); run(40);

        // R5: inverted threshold
        tag = "R5";
        wcfg(8'h34, 8'hFF, 8'd2, 0, 1, 1); run(40);
        wcfg(8'h81, 8'h01, 8'd1, 0, 1, 1); run(40);

        // R6: edge mode, held condition, config rewrite during a true condition
        tag = "R6";
        wcfg(8'h81, 8'h01, 8'd1, 1, 0, 1);
        rq_valid = '1;
        for (int i = 0; i < 6; i++) cycle();
        wcfg(8'h81, 8'h01, 8'd1, 1, 0, 1);
        for (int i = 0; i < 4; i++) cycle();
        rq_valid = '0; cycle(); cycle();
        rq_valid = '1; cycle(); cycle();
        run(40);
        wcfg(8'h34, 8'hFF, 8'd0, 1, 0, 1); run(40);
        wcfg(8'h81, 8'h01, 8'd3, 1, 1, 1); run(40);

        // R7: occupancy weighting on index 0, refused on index 1
        tag = "R7";
        wcfg(8'h80, 8'h01, 8'd0, 0, 0, 1); run(40);
        wcfg(8'h80, 8'h01, 8'd10, 0, 1, 1); run(30);
        wcfg(8'h80, 8'h01, 8'd5, 1, 0, 1); run(30);

        // R8: counting disabled
        tag = "R8";
        wcfg(8'h81, 8'h01, 8'd0, 0, 0, 0); run(30);
        wcfg(8'h80, 8'h01, 8'd0, 0, 0, 0); run(20);

        // R9: software write, write priority over counting, 48-bit wrap
        tag = "R9";
        wcfg(8'h80, 8'h01, 8'd0, 0, 0, 1);
        wcnt(48'hFFFF_FFFF_FFF0);
        occ_level = 6'd63; cycle(); cycle();
        rnd_in(); occ_level = 6'd40; wcnt(48'h1234_5678_9ABC);
        run(10);
        wcnt(MASK);
        run(10);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule